// File: doc/BRIEF.md
# Complementary output dead-time inserter

This block turns one reference PWM signal into a pair of gate drive signals for a half-bridge: a main output that follows the reference and a complementary output that follows its inverse. Each output is held low for a programmable number of clock cycles after the edge that would turn it on. Because of that hold, the high-side and low-side switches never conduct together.

The dead-time setting is an 8-bit count of clock cycles, from 0 to 255. A setting of 0 adds no delay. Turn-off edges get no added delay. A reference pulse that is shorter than the dead time never reaches the output it would enable. The reference is sampled on every rising clock edge, and both outputs are registered. The setting is expected to change only while reset is asserted.

Top module: `dt_inserter`

## Requirements
- R1: A clock edge with `rst` high drives both `hi_out` and `lo_out` low and clears the dead-time progress of both outputs.
- R2: After any clock edge where `ref_in` is sampled 0, `hi_out` is 0. The turn-off has one register of latency and no dead time.
- R3: After any clock edge where `ref_in` is sampled 1, `lo_out` is 0. The turn-off has one register of latency and no dead time.
- R4: With setting N on `dt_cycles`, `hi_out` is 1 after edge k exactly when `ref_in` was sampled 1 at each of the N+1 edges k-N through k since reset.
- R5: With setting N, `lo_out` is 1 after edge k exactly when `ref_in` was sampled 0 at each of the N+1 edges k-N through k since reset.
- R6: With `dt_cycles` = 0, `hi_out` equals the `ref_in` sampled at the previous edge and `lo_out` equals its inverse.
- R7: `hi_out` and `lo_out` are never 1 in the same cycle.
- R8: A reference high or low pulse that lasts N sampled cycles or fewer leaves the output it would enable low for the whole pulse.
- R9: The full setting of 255 is honoured: an output turns on only after 256 consecutive enabling samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dt_cycles | input | 8 | Dead time in clock cycles (0 to 255); change only under reset |
| ref_in | input | 1 | Reference PWM level |
| hi_out | output | 1 | Main (high-side) drive output |
| lo_out | output | 1 | Complementary (low-side) drive output |

## Verification
Every result is due on the first rising edge after `ref_in` is sampled. A turn-off appears one edge after the opposite level is sampled. A turn-on appears on the edge that completes N+1 consecutive enabling samples. The bench drives each new reference level on a falling edge, and at the same moment it queues the levels both outputs must show after the following rising edge. The levels come from a run-length count of enabling samples, compared against N+1. A monitor compares the outputs five nanoseconds after each rising edge, a point where the edge's register updates have settled and the next drive has not yet happened. The test runs at N = 0, 1, 3, 7 and 255, so every turn-on lands on a known cycle.

// File: rtl/dt_pkg.sv
package dt_pkg;

    // Width of the dead-time count
    localparam int DT_W = 8;

    // Which half of the bridge a leg drives
    typedef enum logic {
        LEG_HIGH = 1'b0,
        LEG_LOW  = 1'b1
    } leg_e;

    // Pair of drive levels, indexed by leg
    typedef struct packed {
        logic low;
        logic high;
    } drive_pair_t;

    // Level of the reference that turns a given leg on
    function automatic logic leg_wants_on(leg_e leg, logic ref_lvl);
        return (leg == LEG_LOW) ? ~ref_lvl : ref_lvl;
    endfunction

endpackage

// File: rtl/dt_leg.sv
module dt_leg
    import dt_pkg::*;
#(
    parameter int   DT_W = dt_pkg::DT_W,
    parameter leg_e LEG  = LEG_HIGH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DT_W-1:0] dt_cycles,
    input  logic            ref_in,
    output logic            drive
);

    logic            want_on;
    logic [DT_W-1:0] wait_cnt;
    logic            drive_q;

    assign want_on = leg_wants_on(LEG, ref_in);

    // wait_cnt counts enabling samples up to the dead time, then holds
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
            drive_q  <= 1'b0;
        end else if (!want_on) begin
            wait_cnt <= '0;
            drive_q  <= 1'b0;
        end else if (wait_cnt >= dt_cycles) begin
            drive_q  <= 1'b1;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
            drive_q  <= 1'b0;
        end
    end

    assign drive = drive_q;

endmodule

// File: rtl/dt_inserter.sv
module dt_inserter
    import dt_pkg::*;
#(
    parameter int DT_W = dt_pkg::DT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DT_W-1:0] dt_cycles,
    input  logic            ref_in,
    output logic            hi_out,
    output logic            lo_out
);

    localparam int NUM_LEGS = 2;

    logic [NUM_LEGS-1:0] leg_drive;
    drive_pair_t         pair;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        dt_leg #(
            .DT_W (DT_W),
            .LEG  (leg_e'(g))
        ) u_leg (
            .clk       (clk),
            .rst       (rst),
            .dt_cycles (dt_cycles),
            .ref_in    (ref_in),
            .drive     (leg_drive[g])
        );
    end

    assign pair.high = leg_drive[LEG_HIGH];
    assign pair.low  = leg_drive[LEG_LOW];

    assign hi_out = pair.high;
    assign lo_out = pair.low;

endmodule

// File: rtl/dt_inserter_chk.sv
module dt_inserter_chk #(
    parameter int DT_W = dt_pkg::DT_W
) (
    input logic            clk,
    input logic            rst,
    input logic [DT_W-1:0] dt_cycles,
    input logic            ref_in,
    input logic            hi_out,
    input logic            lo_out
);

    assert_reset_low_R1: assert property (@(posedge clk)
        $past(rst) |-> (!hi_out && !lo_out));

    assert_hi_off_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(ref_in) |-> !hi_out);

    assert_lo_off_R3: assert property (@(posedge clk) disable iff (rst)
        $past(ref_in) |-> !lo_out);

    // R4: a turn-on with nonzero dead time needs two enabling samples in a row
    assert_hi_rise_held_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(hi_out) && $past(dt_cycles) != 0 && !$past(rst, 2))
            |-> ($past(ref_in) && $past(ref_in, 2)));

    assert_lo_rise_held_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(lo_out) && $past(dt_cycles) != 0 && !$past(rst, 2))
            |-> (!$past(ref_in) && !$past(ref_in, 2)));

    assert_zero_dt_follow_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(dt_cycles) == 0 && !$past(rst))
            |-> (hi_out == $past(ref_in) && lo_out == !$past(ref_in)));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(hi_out && lo_out));

endmodule

bind dt_inserter dt_inserter_chk #(.DT_W(DT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dt_cycles (dt_cycles),
    .ref_in    (ref_in),
    .hi_out    (hi_out),
    .lo_out    (lo_out)
);

// File: tb/dt_inserter_test.sv
module dt_inserter_test;

    typedef struct {
        logic  hi;
        logic  lo;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] dt_cycles = 8'd0;
    logic       ref_in = 1'b0;
    logic       hi_out, lo_out;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t sb[$];

    int    run_hi = 0;
    int    run_lo = 0;
    int    cur_n  = 0;
    string seg    = "";

    dt_inserter uut (
        .clk       (clk),
        .rst       (rst),
        .dt_cycles (dt_cycles),
        .ref_in    (ref_in),
        .hi_out    (hi_out),
        .lo_out    (lo_out)
    );

    always #10 clk = ~clk; // 50 MHz

    // Driver: apply one sample and queue what must follow the next edge
    task automatic step(input logic r_rst, input logic r_ref);
        exp_t e;
        @(negedge clk);
        rst    = r_rst;
        ref_in = r_ref;
        if (r_rst) begin
            run_hi = 0;
            run_lo = 0;
            e.hi = 1'b0;
            e.lo = 1'b0;
            e.tag = "R1";
        end else begin
            run_hi = r_ref ? run_hi + 1 : 0;
            run_lo = r_ref ? 0 : run_lo + 1;
            e.hi = (run_hi >= cur_n + 1);
            e.lo = (run_lo >= cur_n + 1);
            e.tag = seg;
        end
        sb.push_back(e);
    endtask

    task automatic hold(input logic r_ref, input int cycles);
        for (int i = 0; i < cycles; i++) step(1'b0, r_ref);
    endtask

    task automatic restart(input int n);
        cur_n = n;
        @(negedge clk);
        dt_cycles = 8'(n);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
    endtask

    // Monitor: compare shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (hi_out !== e.hi) begin
                    fails++;
                    $display("FAIL %s R2 R4 hi_out: actual %b expected %b (N=%0d)",
                             e.tag, hi_out, e.hi, cur_n);
                end
                checks++;
                if (lo_out !== e.lo) begin
                    fails++;
                    $display("FAIL %s R3 R5 lo_out: actual %b expected %b (N=%0d)",
                             e.tag, lo_out, e.lo, cur_n);
                end
                checks++;
                if (hi_out === 1'b1 && lo_out === 1'b1) begin
                    fails++;
                    $display("FAIL R7 overlap: actual hi=%b lo=%b expected not both 1",
                             hi_out, lo_out);
                end
            end
        end
    end

    // Stimulus
    initial begin
        int nset[5] = '{0, 1, 3, 7, 255};
        logic [7:0] lfsr;
        foreach (nset[k]) begin
            int n = nset[k];
            string base;
            base = (n == 0) ? "R6" : (n == 255) ? "R9" : "R4 R5";
            restart(n);
            seg = base;
            hold(1'b0, n + 3);          // R5 complementary turn-on
            hold(1'b1, n + 4);          // R4 main turn-on, R3 turn-off
            hold(1'b0, n + 4);          // R2 turn-off
            if (n > 0) begin
                seg = {base, " R8"};
                hold(1'b1, n);          // R8 high pulse too short
                hold(1'b0, n);          // R8 low pulse too short
                hold(1'b1, n);
                seg = base;
            end
            hold(1'b0, n + 3);
            hold(1'b1, n + 1);          // exactly long enough: one cycle on
            hold(1'b0, n + 1);
            lfsr = 8'hA5 ^ 8'(n);
            for (int i = 0; i < 60; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                step(1'b0, lfsr[0]);
            end
            // R1: reset in the middle of an enabled phase
            hold(1'b1, n + 2);
            step(1'b1, 1'b1);
            seg = {base, " R1"};
            hold(1'b1, n + 2);
        end
        repeat (3) @(posedge clk);
        #5;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule